// File: doc/BRIEF.md
# Paired Audio Channel Buffer with Watermark Interrupts

This block is a single channel of a multi-channel audio data buffer. It holds two independent word FIFOs of equal depth. The capture FIFO is loaded by the audio side and drained by bus reads. The playback FIFO works the other way round: bus writes load it and the audio side drains it. Bus address decoding, the DMA engine and the codec interface sit outside the block. They connect through plain push, pop, data and configuration ports.

Each FIFO takes its own watermark word, which holds an almost-empty level and an almost-full level. Each FIFO drives four level flags, and the eight flags are packed into one status byte. The read and write pointers of each FIFO are exposed in a pointer word, so software can work out occupancy or free space. Six interrupt sources are latched sticky: almost-empty and almost-full for each direction, plus an overflow per direction. Each source has an enable and a write-one-to-clear bit, and the masked sources are ORed into one interrupt line. A soft clear per direction returns that FIFO to empty.

Top module: `audio_chan_buf`

## Requirements
- R1: After reset both FIFOs are empty, both pointer words read zero, no interrupt source is pending, and the interrupt line is low.
- R2: Each FIFO returns words in the order they were accepted. Capture and playback traffic do not affect each other.
- R3: A FIFO is full when it holds DEPTH words. A push into a full FIFO is dropped, even if a pop happens in the same cycle. The dropped push latches that direction's overflow source one clock later.
- R4: A pop from an empty FIFO returns zero and leaves both pointers unchanged. The data port reads zero whenever the FIFO is empty.
- R5: Pointers are log2(DEPTH)+1 bits wide and wrap modulo 2*DEPTH. The pointer word carries the read pointer at bit 16 upward and the write pointer at bit 0 upward. Occupancy is the write pointer minus the read pointer, modulo 2*DEPTH.
- R6: Status bits 3:0 describe the capture FIFO and bits 7:4 the playback FIFO. Within each nibble, bit 0 is full, bit 1 is empty, bit 2 is almost-full and bit 3 is almost-empty.
- R7: In a watermark word, the almost-empty level is the log2(DEPTH)-bit field starting at bit 16 and the almost-full level is the field starting at bit 0. Almost-full holds while occupancy is at or above its level. Almost-empty holds while occupancy is at or below its level.
- R8: Interrupt source bits are: 0 capture almost-empty, 1 capture almost-full, 2 playback almost-empty, 3 playback almost-full, 4 capture overflow, 5 playback overflow. A watermark source latches on the rising edge of its flag. A flag that is already true when reset releases does not latch.
- R9: Latched sources stay set whatever their enable is. The pending output is the latched sources ANDed with the enables, and the interrupt line is the OR of the pending bits.
- R10: A 1 on a clear bit removes that latched source at the next clock. If a new event for the same source arrives in that same cycle, the source stays set.
- R11: Clear bit 0 empties the capture FIFO and clear bit 1 empties the playback FIFO at the next clock. A clear takes priority over a push or pop to the same FIFO in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_push | input | 1 | Audio side pushes a capture word |
| cap_wdata | input | DATA_W | Capture word being pushed |
| cap_pop | input | 1 | Bus read pops the capture head |
| cap_rdata | output | DATA_W | Capture head word, zero when empty |
| pb_push | input | 1 | Bus write pushes a playback word |
| pb_wdata | input | DATA_W | Playback word being pushed |
| pb_pop | input | 1 | Audio side pops the playback head |
| pb_rdata | output | DATA_W | Playback head word, zero when empty |
| cap_wmark | input | 32 | Capture watermark word |
| pb_wmark | input | 32 | Playback watermark word |
| int_en | input | 6 | Per-source interrupt enables |
| int_clr | input | 6 | Per-source write-one-to-clear pulses |
| fifo_clr | input | 2 | Soft clear, bit 0 capture, bit 1 playback |
| status | output | 8 | Level flags of both FIFOs |
| int_raw | output | 6 | Latched interrupt sources |
| int_pend | output | 6 | Latched sources ANDed with enables |
| irq | output | 1 | OR of the pending sources |
| cap_ptrs | output | 32 | Capture pointer word |
| pb_ptrs | output | 32 | Playback pointer word |

## Verification
The bench builds the block with DEPTH set to 8, which makes pointers 4 bits wide and watermark fields 3 bits wide. At that depth a handful of pushes is enough to fill a FIFO, force overflow, and wrap the write pointer past 2*DEPTH. That wrap makes the write pointer field read below the read pointer field. Both watermarks are set to 2 and 6, so the rising edges of almost-empty and almost-full fall inside short sequences that are easy to predict.

// File: rtl/audio_chan_pkg.sv
package audio_chan_pkg;

    localparam int WORD_W    = 32;
    localparam int HI_LSB    = 16;
    localparam int NUM_DIR   = 2;
    localparam int NUM_SRC   = 6;

    localparam int DIR_CAP   = 0;
    localparam int DIR_PB    = 1;

    // interrupt source positions
    localparam int SRC_CAP_AE = 0;
    localparam int SRC_CAP_AF = 1;
    localparam int SRC_PB_AE  = 2;
    localparam int SRC_PB_AF  = 3;
    localparam int SRC_CAP_OV = 4;
    localparam int SRC_PB_OV  = 5;

    // watermark sources are edge detected, overflow sources are pulses
    localparam logic [NUM_SRC-1:0] SRC_EDGE_MASK = 6'b001111;

    // bit 0 full, bit 1 empty, bit 2 almost-full, bit 3 almost-empty
    typedef struct packed {
        logic aempty;
        logic afull;
        logic empty;
        logic full;
    } fifo_flags_t;

    function automatic logic [WORD_W-1:0] pack_pair(
        input logic [HI_LSB-1:0] hi,
        input logic [HI_LSB-1:0] lo
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/achan_fifo.sv
module achan_fifo
    import audio_chan_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    input  logic [AW-1:0]     ae_lvl,
    input  logic [AW-1:0]     af_lvl,
    output fifo_flags_t       flags,
    output logic              overflow,
    output logic [PW-1:0]     rd_ptr,
    output logic [PW-1:0]     wr_ptr
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     occ;
    logic              do_push;
    logic              do_pop;

    always_comb begin
        occ          = wr_ptr - rd_ptr;
        flags.full   = (occ == PW'(DEPTH));
        flags.empty  = (occ == '0);
        flags.afull  = (occ >= {1'b0, af_lvl});
        flags.aempty = (occ <= {1'b0, ae_lvl});
        do_push      = push && !flags.full  && !clr;
        do_pop       = pop  && !flags.empty && !clr;
        overflow     = push && flags.full   && !clr;
        rdata        = flags.empty ? '0 : mem[rd_ptr[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (push && flags.full && !clr) |=> $stable(wr_ptr));

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && flags.empty && !clr) |=> $stable(rd_ptr));

    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr - rd_ptr) <= PW'(DEPTH));

    assert_soft_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rd_ptr == '0 && wr_ptr == '0));

endmodule

// File: rtl/achan_irq.sv
module achan_irq
    import audio_chan_pkg::*;
#(
    parameter int N                    = NUM_SRC,
    parameter logic [N-1:0] EDGE_MASK  = SRC_EDGE_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw,
    output logic [N-1:0] pend,
    output logic         line
);

    logic [N-1:0] ev;

    for (genvar i = 0; i < N; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b1;
                else     prev_q <= src[i];
            end
            assign ev[i] = src[i] && !prev_q;
        end else begin : g_pulse
            assign ev[i] = src[i];
        end

        always_ff @(posedge clk) begin
            if (rst) raw[i] <= 1'b0;
            else     raw[i] <= (raw[i] && !clr[i]) || ev[i];
        end

        assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> raw[i]);

        assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !ev[i]) |=> !raw[i]);

        assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
            (raw[i] && !clr[i]) |=> raw[i]);
    end

    assign pend = raw & en;
    assign line = |pend;

endmodule

// File: rtl/audio_chan_buf.sv
module audio_chan_buf
    import audio_chan_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_push,
    input  logic [DATA_W-1:0] cap_wdata,
    input  logic              cap_pop,
    output logic [DATA_W-1:0] cap_rdata,
    input  logic              pb_push,
    input  logic [DATA_W-1:0] pb_wdata,
    input  logic              pb_pop,
    output logic [DATA_W-1:0] pb_rdata,
    input  logic [31:0]       cap_wmark,
    input  logic [31:0]       pb_wmark,
    input  logic [5:0]        int_en,
    input  logic [5:0]        int_clr,
    input  logic [1:0]        fifo_clr,
    output logic [7:0]        status,
    output logic [5:0]        int_raw,
    output logic [5:0]        int_pend,
    output logic              irq,
    output logic [31:0]       cap_ptrs,
    output logic [31:0]       pb_ptrs
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [WORD_W-1:0] WM_USED =
        ({{(WORD_W-AW){1'b0}}, {AW{1'b1}}} << HI_LSB) |
         {{(WORD_W-AW){1'b0}}, {AW{1'b1}}};

    logic [NUM_DIR-1:0] push_v, pop_v, ovf_v;
    logic [DATA_W-1:0]  wdata_v [NUM_DIR];
    logic [DATA_W-1:0]  rdata_v [NUM_DIR];
    logic [WORD_W-1:0]  wmark_v [NUM_DIR];
    logic [WORD_W-1:0]  ptrs_v  [NUM_DIR];
    fifo_flags_t        flags_v [NUM_DIR];
    logic [NUM_DIR-1:0] wm_unused;
    logic [NUM_SRC-1:0] src;

    assign push_v[DIR_CAP]  = cap_push;
    assign push_v[DIR_PB]   = pb_push;
    assign pop_v[DIR_CAP]   = cap_pop;
    assign pop_v[DIR_PB]    = pb_pop;
    assign wdata_v[DIR_CAP] = cap_wdata;
    assign wdata_v[DIR_PB]  = pb_wdata;
    assign wmark_v[DIR_CAP] = cap_wmark;
    assign wmark_v[DIR_PB]  = pb_wmark;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        logic [PW-1:0] rd_ptr, wr_ptr;

        achan_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo (
            .clk      (clk),
            .rst      (rst),
            .clr      (fifo_clr[d]),
            .push     (push_v[d]),
            .wdata    (wdata_v[d]),
            .pop      (pop_v[d]),
            .rdata    (rdata_v[d]),
            .ae_lvl   (wmark_v[d][HI_LSB +: AW]),
            .af_lvl   (wmark_v[d][0 +: AW]),
            .flags    (flags_v[d]),
            .overflow (ovf_v[d]),
            .rd_ptr   (rd_ptr),
            .wr_ptr   (wr_ptr)
        );

        assign ptrs_v[d]    = pack_pair(HI_LSB'(rd_ptr), HI_LSB'(wr_ptr));
        assign wm_unused[d] = ^(wmark_v[d] & ~WM_USED);
    end

    always_comb begin
        src             = '0;
        src[SRC_CAP_AE] = flags_v[DIR_CAP].aempty;
        src[SRC_CAP_AF] = flags_v[DIR_CAP].afull;
        src[SRC_PB_AE]  = flags_v[DIR_PB].aempty;
        src[SRC_PB_AF]  = flags_v[DIR_PB].afull;
        src[SRC_CAP_OV] = ovf_v[DIR_CAP];
        src[SRC_PB_OV]  = ovf_v[DIR_PB];
    end

    achan_irq #(.N(NUM_SRC), .EDGE_MASK(SRC_EDGE_MASK)) i_irq (
        .clk  (clk),
        .rst  (rst),
        .src  (src),
        .en   (int_en),
        .clr  (int_clr),
        .raw  (int_raw),
        .pend (int_pend),
        .line (irq)
    );

    assign status    = {flags_v[DIR_PB], flags_v[DIR_CAP]};
    assign cap_rdata = rdata_v[DIR_CAP];
    assign pb_rdata  = rdata_v[DIR_PB];
    assign cap_ptrs  = ptrs_v[DIR_CAP];
    assign pb_ptrs   = ptrs_v[DIR_PB];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (int_raw == '0 && cap_ptrs == '0 && pb_ptrs == '0));

    assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(status[0] && status[1]) && !(status[4] && status[5]));

endmodule

// File: tb/test_audio_chan_buf.sv
module test_audio_chan_buf;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cap_push = 1'b0, cap_pop = 1'b0;
    logic              pb_push = 1'b0, pb_pop = 1'b0;
    logic [DATA_W-1:0] cap_wdata = '0, pb_wdata = '0;
    logic [DATA_W-1:0] cap_rdata, pb_rdata;
    logic [31:0]       cap_wmark = (32'd2 << 16) | 32'd6;
    logic [31:0]       pb_wmark  = (32'd2 << 16) | 32'd6;
    logic [5:0]        int_en = '0, int_clr = '0;
    logic [1:0]        fifo_clr = '0;
    logic [7:0]        status;
    logic [5:0]        int_raw, int_pend;
    logic              irq;
    logic [31:0]       cap_ptrs, pb_ptrs;

    int checks = 0;
    int errors = 0;
    logic [31:0] cap_q [$];
    logic [31:0] pb_q  [$];

    always #2.5 clk = ~clk;

    audio_chan_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_audio_chan_buf (
        .clk(clk), .rst(rst),
        .cap_push(cap_push), .cap_wdata(cap_wdata), .cap_pop(cap_pop), .cap_rdata(cap_rdata),
        .pb_push(pb_push), .pb_wdata(pb_wdata), .pb_pop(pb_pop), .pb_rdata(pb_rdata),
        .cap_wmark(cap_wmark), .pb_wmark(pb_wmark),
        .int_en(int_en), .int_clr(int_clr), .fifo_clr(fifo_clr),
        .status(status), .int_raw(int_raw), .int_pend(int_pend), .irq(irq),
        .cap_ptrs(cap_ptrs), .pb_ptrs(pb_ptrs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each pop compares the head against the model queue
    always @(negedge clk) begin
        if (!rst && cap_pop) begin
            logic [31:0] e;
            e = (cap_q.size() > 0) ? cap_q.pop_front() : 32'h0;
            chk("R2/R4 capture data", cap_rdata, e);
        end
        if (!rst && pb_pop) begin
            logic [31:0] e;
            e = (pb_q.size() > 0) ? pb_q.pop_front() : 32'h0;
            chk("R2/R4 playback data", pb_rdata, e);
        end
    end

    task automatic cap_write(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cap_push = 1'b1; cap_wdata = base + i;
            if (cap_q.size() < DEPTH) cap_q.push_back(base + i);
        end
        @(posedge clk); #1; cap_push = 1'b0;
    endtask

    task automatic pb_write(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            pb_push = 1'b1; pb_wdata = base + i;
            if (pb_q.size() < DEPTH) pb_q.push_back(base + i);
        end
        @(posedge clk); #1; pb_push = 1'b0;
    endtask

    task automatic cap_read(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; cap_pop = 1'b1;
        end
        @(posedge clk); #1; cap_pop = 1'b0;
    endtask

    task automatic pb_read(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; pb_pop = 1'b1;
        end
        @(posedge clk); #1; pb_pop = 1'b0;
    endtask

    task automatic clr_pulse(input logic [5:0] m);
        @(posedge clk); #1; int_clr = m;
        @(posedge clk); #1; int_clr = '0;
    endtask

    task automatic settle;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        settle();
        // R1 reset state, R8 no latch of a condition present at reset
        chk("R1 int_raw", {26'b0, int_raw}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 cap_ptrs", cap_ptrs, 32'h0);
        chk("R1 pb_ptrs", pb_ptrs, 32'h0);
        chk("R6 status reset", {24'b0, status}, 32'hAA);
        chk("R4 empty rdata", cap_rdata, 32'h0);

        // R2/R5 partial fill, almost-empty falls with no event
        cap_write(5, 32'h100);
        settle();
        chk("R5 cap_ptrs 5", cap_ptrs, 32'h0000_0005);
        chk("R6 status occ5", {24'b0, status}, 32'hA0);
        chk("R8 no event on fall", {26'b0, int_raw}, 32'h0);

        // R7/R8 almost-full rising edge at occupancy 6
        cap_write(1, 32'h105);
        settle();
        chk("R7 status afull", {24'b0, status}, 32'hA4);
        chk("R8 cap afull latched", {26'b0, int_raw}, 32'h02);
        chk("R9 raw without enable", {31'b0, irq}, 32'h0);
        int_en = 6'b000010;
        @(negedge clk);
        chk("R9 irq enabled", {31'b0, irq}, 32'h1);
        chk("R9 pend", {26'b0, int_pend}, 32'h02);

        // R3 fill to full then overflow
        cap_write(3, 32'h106);
        settle();
        chk("R3 status full", {24'b0, status}, 32'hA5);
        chk("R3 overflow latched", {26'b0, int_raw}, 32'h12);
        chk("R3 wr stays at depth", cap_ptrs, 32'h0000_0008);

        // R10 clear while flag still high
        clr_pulse(6'b000010);
        settle();
        chk("R10 clear removes", {26'b0, int_raw}, 32'h10);
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);

        // R2 drain in order, R4 extra read returns zero, R8 almost-empty rise
        cap_read(9);
        settle();
        chk("R8 cap aempty latched", {26'b0, int_raw}, 32'h11);
        chk("R4 pointers unchanged", cap_ptrs, 32'h0008_0008);
        chk("R6 status drained", {24'b0, status}, 32'hAA);

        // R5 wrap of the write pointer
        cap_write(8, 32'h200);
        settle();
        chk("R5 wrapped ptrs", cap_ptrs, 32'h0008_0000);
        chk("R3 full after wrap", {24'b0, status}, 32'hA5);
        chk("R8 afull again", {26'b0, int_raw}, 32'h13);

        // R11 capture soft clear wins over push
        @(posedge clk); #1;
        fifo_clr = 2'b01; cap_push = 1'b1; cap_wdata = 32'hDEAD; cap_q.delete();
        @(posedge clk); #1;
        fifo_clr = 2'b00; cap_push = 1'b0;
        settle();
        chk("R11 cap cleared", cap_ptrs, 32'h0);
        chk("R11 status cleared", {24'b0, status}, 32'hAA);
        chk("R11 cap rdata empty", cap_rdata, 32'h0);

        clr_pulse(6'h3F);
        settle();
        chk("R10 clear all", {26'b0, int_raw}, 32'h0);

        // playback fill with overflow
        pb_write(9, 32'h300);
        settle();
        chk("R3 pb overflow and afull", {26'b0, int_raw}, 32'h28);
        chk("R6 pb full status", {24'b0, status}, 32'h5A);
        chk("R5 pb_ptrs", pb_ptrs, 32'h0000_0008);

        // R10 event and clear in the same cycle: event wins
        @(posedge clk); #1;
        pb_push = 1'b1; pb_wdata = 32'hBEEF; int_clr = 6'b100000;
        @(posedge clk); #1;
        pb_push = 1'b0; int_clr = '0;
        settle();
        chk("R10 event wins", {26'b0, int_raw}, 32'h28);
        clr_pulse(6'b100000);
        settle();
        chk("R10 clear after", {26'b0, int_raw}, 32'h08);

        // R2 playback order, independent of capture
        pb_read(3);
        settle();
        chk("R5 pb ptrs after read", pb_ptrs, 32'h0003_0008);
        chk("R6 pb mid status", {24'b0, status}, 32'h0A);
        chk("R2 capture untouched", cap_ptrs, 32'h0);

        // R9 masking
        int_en = 6'h3F;
        @(negedge clk);
        chk("R9 irq all enabled", {31'b0, irq}, 32'h1);
        int_en = 6'h00;
        #1;
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        chk("R9 raw kept", {26'b0, int_raw}, 32'h08);

        // R11 playback soft clear with push
        @(posedge clk); #1;
        fifo_clr = 2'b10; pb_push = 1'b1; pb_wdata = 32'hCAFE; pb_q.delete();
        @(posedge clk); #1;
        fifo_clr = 2'b00; pb_push = 1'b0;
        settle();
        chk("R11 pb cleared", pb_ptrs, 32'h0);
        chk("R11 status both empty", {24'b0, status}, 32'hAA);
        chk("R8 pb aempty latched", {26'b0, int_raw}, 32'h0C);

        pb_read(1);
        settle();
        chk("R4 pb empty pop ptrs", pb_ptrs, 32'h0);

        finish_run();
    end

endmodule